// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a synchronous host and an external asynchronous static RAM of 512K bytes (19-bit address, 8-bit data). The host raises a request with an address, a direction flag and, for writes, a data byte. The sequencer then runs one complete memory cycle on the active-low chip-select, write-strobe and output-enable pins. It holds every phase for a whole number of clock cycles, and each count is derived from a nanosecond-style minimum given as a parameter.

Each timing minimum is a parameter in picoseconds. It is turned into a cycle count by rounding up, and the result is never below one cycle. Reads and writes share one data bus. The block drives that bus only through a separate output-enable pin. After every read it spends a turnaround window with all strobes released before it may drive the bus again. One `ack_o` pulse finishes each access. For a read, the captured byte is on `rdata_o` in the same cycle as that pulse.

Top module: `sram_ctrl`

## Requirements
- R1: While `rst_ni` is low, `sram_ce_no`, `sram_we_no` and `sram_oe_no` are 1, and `sram_dq_oe_o` and `ack_o` are 0.
- R2: A write holds `sram_ce_no`=0, `sram_we_no`=0 and `sram_oe_no`=1 for exactly WR_CYC cycles. During those cycles `sram_dq_oe_o`=1, and `sram_addr_o` and `sram_dq_o` stay constant. WR_CYC is the largest of the rounded write-cycle, write-pulse, address-to-end and data-setup counts.
- R3: A write stores `wdata_i` at `addr_i`, and this holds up to the top address 19'h7FFFF. The `ack_o` pulse comes WR_CYC+1 cycles after the accepting edge, counted as the first cycle after that edge.
- R4: A read holds `sram_ce_no`=0, `sram_oe_no`=0, `sram_we_no`=1 and `sram_dq_oe_o`=0 for exactly RD_CYC cycles. RD_CYC is the larger of the rounded address-access and output-enable-access counts. `sram_dq_i` is captured on the last of those edges, and `ack_o` rises RD_CYC+1 cycles after acceptance, with the byte on `rdata_o`.
- R5: Each count equals ceil(time_ps / CLK_PS), with a minimum of 1. With the bench settings (CLK_PS 20000; access 45000 ps; write cycle 50000 ps; release 25000 ps), RD_CYC=3, WR_CYC=3 and TURN_CYC=2.
- R6: After each read, all three strobes stay 1 and `sram_dq_oe_o` stays 0 for TURN_CYC cycles. `sram_dq_oe_o` is never 1 while the memory may still be driving the bus.
- R7: A request is accepted only when the sequencer is idle. A request raised during an access or during the turnaround is dropped, not queued.
- R8: A request present in the cycle in which a write's `ack_o` is high is accepted at the end of that cycle.
- R9: `ack_o` is high for one cycle at a time, and exactly once per accepted request.
- R10: `sram_addr_o` is constant for as long as `sram_ce_no` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, sampled while idle |
| we_i | input | 1 | 1 selects a write, 0 a read |
| addr_i | input | 19 | Byte address |
| wdata_i | input | 8 | Write data |
| ack_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 8 | Captured read data |
| sram_addr_o | output | 19 | Memory address pins |
| sram_ce_no | output | 1 | Chip select, active low |
| sram_we_no | output | 1 | Write strobe, active low |
| sram_oe_no | output | 1 | Output enable, active low |
| sram_dq_o | output | 8 | Data driven toward the memory |
| sram_dq_oe_o | output | 1 | Tri-state enable for `sram_dq_o` |
| sram_dq_i | input | 8 | Data bus as seen from the memory side |

## Verification
Two events can fall in the same cycle: completion of a write (its `ack_o` cycle) and acceptance of the next request. The bench provokes this by holding `req_i` high across a write and presenting a second write's address and data in the ack cycle. It then checks that the strobes fall in the very next cycle with the new address and that both bytes read back. A second case holds a request across a read's turnaround. The bench checks that the request waits until the strobes have been released for TURN_CYC cycles, and a memory model that keeps driving one cycle past the read reports any bus contention.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR, ST_TURN} st_e;

  typedef struct packed {
    logic ce_n;
    logic we_n;
    logic oe_n;
    logic dq_oe;
  } strobe_t;

  function automatic int unsigned ps_to_cyc(int unsigned t_ps, int unsigned clk_ps);
    int unsigned c;
    c = (t_ps + clk_ps - 1) / clk_ps;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic strobe_t strobes_for(st_e s);
    strobe_t r;
    case (s)
      ST_RD:   r = '{ce_n: 1'b0, we_n: 1'b1, oe_n: 1'b0, dq_oe: 1'b0};
      ST_WR:   r = '{ce_n: 1'b0, we_n: 1'b0, oe_n: 1'b1, dq_oe: 1'b1};
      default: r = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};
    endcase
    return r;
  endfunction

endpackage

// File: rtl/sram_cyc_timer.sv
module sram_cyc_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             last_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q == '0);

endmodule

// File: rtl/sram_seq.sv
module sram_seq
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned CNT_W    = 4,
  parameter int unsigned RD_CYC   = 1,
  parameter int unsigned WR_CYC   = 1,
  parameter int unsigned TURN_CYC = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic             last_i,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o,
  output logic             accept_o,
  output logic             cap_o,
  output logic             ack_set_o,
  output strobe_t          strobe_o
);

  st_e st_q, st_d;

  always_comb begin
    st_d       = st_q;
    load_o     = 1'b0;
    load_val_o = '0;
    accept_o   = 1'b0;
    cap_o      = 1'b0;
    ack_set_o  = 1'b0;
    case (st_q)
      ST_IDLE: if (req_i) begin
        accept_o   = 1'b1;
        load_o     = 1'b1;
        st_d       = we_i ? ST_WR : ST_RD;
        load_val_o = we_i ? CNT_W'(WR_CYC - 1) : CNT_W'(RD_CYC - 1);
      end
      ST_RD: if (last_i) begin
        cap_o      = 1'b1;
        ack_set_o  = 1'b1;
        load_o     = 1'b1;
        load_val_o = CNT_W'(TURN_CYC - 1);
        st_d       = ST_TURN;
      end
      ST_WR: if (last_i) begin
        ack_set_o = 1'b1;
        st_d      = ST_IDLE;
      end
      default: if (last_i) st_d = ST_IDLE;
    endcase
  end

  // strobes come straight from flops so the pins never glitch on a decode
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      strobe_o <= strobes_for(ST_IDLE);
    end else begin
      st_q     <= st_d;
      strobe_o <= strobes_for(st_d);
    end
  end

endmodule

// File: rtl/sram_io_regs.sv
module sram_io_regs #(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              cap_i,
  input  logic              ack_set_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] dq_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ack_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o  <= '0;
      dq_o    <= '0;
      rdata_o <= '0;
      ack_o   <= 1'b0;
    end else begin
      ack_o <= ack_set_i;
      if (accept_i) begin
        addr_o <= addr_i;
        dq_o   <= wdata_i;
      end
      if (cap_i) rdata_o <= dq_i;
    end
  end

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned CLK_PS  = 20000,
  parameter int unsigned ADDR_W  = 19,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned T_AA_PS = 10000,
  parameter int unsigned T_OE_PS = 5000,
  parameter int unsigned T_WC_PS = 10000,
  parameter int unsigned T_WP_PS = 8000,
  parameter int unsigned T_AW_PS = 10000,
  parameter int unsigned T_DS_PS = 6000,
  parameter int unsigned T_HZ_PS = 5000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ack_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic              sram_ce_no,
  output logic              sram_we_no,
  output logic              sram_oe_no,
  output logic [DATA_W-1:0] sram_dq_o,
  output logic              sram_dq_oe_o,
  input  logic [DATA_W-1:0] sram_dq_i
);

  localparam int unsigned RD_CYC   = max2(ps_to_cyc(T_AA_PS, CLK_PS), ps_to_cyc(T_OE_PS, CLK_PS));
  localparam int unsigned WR_CYC   = max2(max2(ps_to_cyc(T_WC_PS, CLK_PS), ps_to_cyc(T_WP_PS, CLK_PS)),
                                          max2(ps_to_cyc(T_AW_PS, CLK_PS), ps_to_cyc(T_DS_PS, CLK_PS)));
  localparam int unsigned TURN_CYC = ps_to_cyc(T_HZ_PS, CLK_PS);
  localparam int unsigned MAX_CYC  = max2(max2(RD_CYC, WR_CYC), TURN_CYC);
  localparam int unsigned CNT_W    = $clog2(MAX_CYC + 1);

  logic             load, last, accept, cap, ack_set;
  logic [CNT_W-1:0] load_val;
  strobe_t          strb;

  sram_cyc_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i, .rst_ni,
    .load_i(load), .load_val_i(load_val), .last_o(last)
  );

  sram_seq #(
    .CNT_W(CNT_W), .RD_CYC(RD_CYC), .WR_CYC(WR_CYC), .TURN_CYC(TURN_CYC)
  ) u_seq (
    .clk_i, .rst_ni, .req_i, .we_i,
    .last_i(last), .load_o(load), .load_val_o(load_val),
    .accept_o(accept), .cap_o(cap), .ack_set_o(ack_set), .strobe_o(strb)
  );

  sram_io_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_io (
    .clk_i, .rst_ni,
    .accept_i(accept), .cap_i(cap), .ack_set_i(ack_set),
    .addr_i, .wdata_i, .dq_i(sram_dq_i),
    .addr_o(sram_addr_o), .dq_o(sram_dq_o), .rdata_o, .ack_o
  );

  assign sram_ce_no   = strb.ce_n;
  assign sram_we_no   = strb.we_n;
  assign sram_oe_no   = strb.oe_n;
  assign sram_dq_oe_o = strb.dq_oe;

endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned RD_CYC = 1,
  parameter int unsigned WR_CYC = 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ack_o,
  input logic [ADDR_W-1:0] sram_addr_o,
  input logic              sram_ce_no,
  input logic              sram_we_no,
  input logic              sram_oe_no,
  input logic              sram_dq_oe_o
);

  logic [15:0] wr_len, rd_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_len <= '0;
      rd_len <= '0;
    end else begin
      wr_len <= !sram_we_no ? wr_len + 16'd1 : 16'd0;
      rd_len <= !sram_oe_no ? rd_len + 16'd1 : 16'd0;
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni)
      assert_reset_idle_R1: assert (sram_ce_no && sram_we_no && sram_oe_no && !sram_dq_oe_o && !ack_o);
  end

  assert_write_strobes_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_we_no |-> (!sram_ce_no && sram_oe_no && sram_dq_oe_o));

  assert_write_len_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_we_no) |-> (wr_len == 16'(WR_CYC)));

  assert_read_strobes_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_oe_no |-> (!sram_ce_no && sram_we_no && !sram_dq_oe_o));

  assert_read_len_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_oe_no) |-> (rd_len == 16'(RD_CYC)));

  assert_turn_no_drive_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_oe_no) |-> !sram_dq_oe_o ##1 !sram_dq_oe_o);

  assert_ack_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);

  assert_addr_stable_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sram_ce_no && $past(!sram_ce_no)) |-> $stable(sram_addr_o));

endmodule

bind sram_ctrl sram_ctrl_chk #(
  .ADDR_W(ADDR_W), .RD_CYC(RD_CYC), .WR_CYC(WR_CYC)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ack_o(ack_o), .sram_addr_o(sram_addr_o),
  .sram_ce_no(sram_ce_no), .sram_we_no(sram_we_no), .sram_oe_no(sram_oe_no),
  .sram_dq_oe_o(sram_dq_oe_o)
);

// File: tb/tb_sram_ctrl.sv
`timescale 1ns/1ps
module tb_sram_ctrl;

  // 20 ns clock: 45 ns access -> 3, 50 ns write cycle -> 3, 25 ns release -> 2
  localparam int RD_CYC   = 3;
  localparam int WR_CYC   = 3;
  localparam int TURN_CYC = 2;

  logic        clk, rst_ni;
  logic        req, we;
  logic [18:0] addr;
  logic [7:0]  wdata;
  logic        ack_o;
  logic [7:0]  rdata_o;
  logic [18:0] sram_addr_o;
  logic        sram_ce_no, sram_we_no, sram_oe_no, sram_dq_oe_o;
  logic [7:0]  sram_dq_o, sram_dq_i;

  int checks = 0, errors = 0;
  bit done = 0;

  sram_ctrl #(
    .CLK_PS(20000), .T_AA_PS(45000), .T_OE_PS(5000), .T_WC_PS(50000),
    .T_WP_PS(30000), .T_AW_PS(10000), .T_DS_PS(6000), .T_HZ_PS(25000)
  ) dut (
    .clk_i(clk), .rst_ni, .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .ack_o, .rdata_o, .sram_addr_o, .sram_ce_no, .sram_we_no, .sram_oe_no,
    .sram_dq_o, .sram_dq_oe_o, .sram_dq_i
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // ---------------- memory model ----------------
  logic [7:0] mem [logic [18:0]];
  logic       read_now, hold_q, mdl_drive;
  int         rd_age = 0, wr_len = 0;
  logic [18:0] wa, prev_addr;
  logic [7:0]  wd, mdl_val;
  logic        prev_ce_n = 1'b1, prev_ack = 1'b0;
  int acc_cnt = 0, ack_cnt = 0, ack_dbl = 0, contention = 0, stab_err = 0, addr_err = 0;

  assign read_now  = !sram_ce_no && !sram_oe_no && sram_we_no;
  assign mdl_drive = read_now || hold_q;

  always @* begin
    mdl_val = mem.exists(sram_addr_o) ? mem[sram_addr_o] : 8'h00;
    if (!(read_now && rd_age >= RD_CYC)) mdl_val = ~mdl_val;
  end

  assign sram_dq_i = mdl_drive ? mdl_val : (sram_dq_oe_o ? sram_dq_o : 8'h00);

  initial hold_q = 1'b0;

  always @(negedge clk) begin
    if (sram_dq_oe_o && mdl_drive) contention++;
    hold_q = read_now;
    rd_age = read_now ? rd_age + 1 : 0;
    if (!sram_ce_no && !sram_we_no) begin
      if (wr_len == 0) begin
        wa = sram_addr_o;
        wd = sram_dq_o;
      end else if (sram_addr_o != wa || sram_dq_o != wd) stab_err++;
      if (!sram_oe_no || !sram_dq_oe_o) stab_err++;
      wr_len++;
    end else if (wr_len != 0) begin
      chk(wr_len == WR_CYC, "R2", "write pulse cycles", wr_len, WR_CYC);
      mem[wa] = wd;
      wr_len = 0;
    end
    if (!sram_ce_no && prev_ce_n) acc_cnt++;
    if (!sram_ce_no && !prev_ce_n && sram_addr_o != prev_addr) addr_err++;
    if (ack_o) ack_cnt++;
    if (ack_o && prev_ack) ack_dbl++;
    prev_ce_n = sram_ce_no;
    prev_addr = sram_addr_o;
    prev_ack  = ack_o;
  end

  // ---------------- scenarios ----------------
  task automatic wait_ack(output int lat);
    lat = 1;
    while (!ack_o && lat < 50) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic do_write(input logic [18:0] a, input logic [7:0] d);
    int lat;
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0;
    wait_ack(lat);
    chk(lat == WR_CYC + 1, "R3", "write ack latency (R5 count)", lat, WR_CYC + 1);
  endtask

  task automatic do_read(input logic [18:0] a, input logic [7:0] exp);
    int lat;
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
    wait_ack(lat);
    chk(lat == RD_CYC + 1, "R4", "read ack latency (R5 count)", lat, RD_CYC + 1);
    chk(rdata_o == exp, "R4", "read data", rdata_o, exp);
    repeat (TURN_CYC) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_ni = 1'b1; req = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    #1 rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    chk(sram_ce_no && sram_we_no && sram_oe_no, "R1", "strobes in reset",
        {sram_ce_no, sram_we_no, sram_oe_no}, 3'b111);
    chk(!sram_dq_oe_o && !ack_o, "R1", "dq_oe/ack in reset", {sram_dq_oe_o, ack_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_basic();
    do_write(19'h7FFFF, 8'hA5);
    do_write(19'h00000, 8'h3C);
    do_write(19'h2A5C3, 8'h81);
    do_read(19'h7FFFF, 8'hA5);   // R3 top address
    do_read(19'h00000, 8'h3C);   // R3
    do_read(19'h2A5C3, 8'h81);   // R3
  endtask

  task automatic t_busy_ignore();  // R7
    int a0, k0, lat;
    a0 = acc_cnt; k0 = ack_cnt;
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 19'h01234; wdata = 8'h5A;
    @(negedge clk);
    we = 1'b0; addr = 19'h05555;
    @(negedge clk);
    @(negedge clk);
    req = 1'b0;
    wait_ack(lat);
    repeat (4) @(negedge clk);
    chk(acc_cnt - a0 == 1, "R7", "accesses for one accepted request", acc_cnt - a0, 1);
    chk(ack_cnt - k0 == 1, "R7", "acks for one accepted request", ack_cnt - k0, 1);
    chk(sram_ce_no, "R7", "idle after busy request", sram_ce_no, 1);
    do_read(19'h01234, 8'h5A);
  endtask

  task automatic t_back_to_back();  // R8
    int lat;
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 19'h10001; wdata = 8'hC3;
    @(negedge clk);
    wait_ack(lat);
    addr = 19'h10002; wdata = 8'h3D;
    @(negedge clk);
    req = 1'b0;
    chk(!sram_ce_no && !sram_we_no, "R8", "write accepted in ack cycle",
        {sram_ce_no, sram_we_no}, 0);
    chk(sram_addr_o == 19'h10002, "R8", "second address", sram_addr_o, 19'h10002);
    wait_ack(lat);
    chk(lat == WR_CYC + 1, "R8", "second write latency", lat, WR_CYC + 1);
    do_read(19'h10001, 8'hC3);
    do_read(19'h10002, 8'h3D);
  endtask

  task automatic t_turnaround();  // R6
    int i;
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = 19'h7FFFF;
    @(negedge clk);
    we = 1'b1; addr = 19'h00777; wdata = 8'hE7;
    i = 1;
    while (!ack_o && i < 50) begin @(negedge clk); i++; end
    chk(rdata_o == 8'hA5, "R6", "read data before turnaround", rdata_o, 8'hA5);
    chk(sram_ce_no && sram_oe_no && !sram_dq_oe_o, "R6", "released in turnaround 1",
        {sram_ce_no, sram_oe_no, sram_dq_oe_o}, 3'b110);
    @(negedge clk); i++;
    chk(sram_ce_no && sram_oe_no && !sram_dq_oe_o, "R6", "released in turnaround 2",
        {sram_ce_no, sram_oe_no, sram_dq_oe_o}, 3'b110);
    while (sram_we_no && i < 50) begin @(negedge clk); i++; end
    req = 1'b0;
    chk(i == RD_CYC + TURN_CYC + 2, "R6", "cycle of held write start", i, RD_CYC + TURN_CYC + 2);
    wait_ack(i);
    do_read(19'h00777, 8'hE7);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_busy_ignore();
    t_back_to_back();
    t_turnaround();
    repeat (3) @(negedge clk);
    chk(contention == 0, "R6", "bus contention cycles", contention, 0);
    chk(stab_err == 0, "R2", "write strobe/data stability errors", stab_err, 0);
    chk(addr_err == 0, "R10", "address changes while selected", addr_err, 0);
    chk(ack_dbl == 0, "R9", "back-to-back ack cycles", ack_dbl, 0);
    chk(ack_cnt == acc_cnt, "R9", "acks vs accesses", ack_cnt, acc_cnt);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule